// File: doc/BRIEF.md
# Bus-Programmed Serial Transmitter with Modem Handshake

This block is the transmit half of an asynchronous serial port that a processor drives through four byte-wide registers. A register-select input and a read/write input pick the target: the transmit holding register or the control register on writes, and the receive holding register or the status register on reads. The control register holds the character format (5 to 8 data bits, parity on or off, even or odd parity, one or two stop bits) and a transmit-request flag. The flag drives the request-to-send output and enables the interrupt output.

A character written to the holding register moves into the shift register when clear-to-send is low. It is then sent in this order: a low start bit, the data bits with the LSB first, an optional parity bit and one or two high stop bits. Each bit lasts `TICKS` transmitter clocks, 16 by default. One clock after each transfer the holding-empty flag is set, so software can write the next character. That character follows the last stop bit with no idle gap. When both registers are empty, a final interrupt tells software that transmit-request can be cleared.

The shifter runs five named states. `ST_IDLE` goes to `ST_START` on a transfer (holding register full and clear-to-send low). `ST_START` goes to `ST_DATA` at the end of the bit. `ST_DATA` goes to `ST_PARITY` after the last data bit when parity is enabled, and to `ST_STOP` otherwise. `ST_PARITY` goes to `ST_STOP`. `ST_STOP` either repeats once for a second stop bit, goes to `ST_START` on a back-to-back transfer, or returns to `ST_IDLE`.

Top module: `bus_uart_tx`

## Requirements
- R1: Register decode: a write (`rd_nwr`=0) with `reg_sel`=0 loads the holding register, and with `reg_sel`=1 loads the control register. A read (`rd_nwr`=1) with `reg_sel`=0 returns the receive holding register, which is always 0x00. A read with `reg_sel`=1 returns status: bit0 = holding empty, bit1 = shift register empty, bit2 = interrupt pending, all other bits 0. The status after reset is 0x03.
- R2: `clr_n` low resets the control register, the status flags and the shifter. It forces `sdo` high and `rts_n` high at once. After clear the format is 5 data bits, no parity and one stop bit.
- R3: A register write or read takes effect only on a cycle with `strobe`=1 and `cs_a`, `cs_b` and `cs_c` all high. With any chip select low, a write changes nothing.
- R4: Control bits: [1:0] word length (0..3 gives 5..8 bits), [2] parity enable, [3] even parity when 1 and odd when 0, [4] two stop bits, [7] transmit-request. A control write with bit7=0 loads the format and clears transmit-request. A control write with bit7=1 sets transmit-request and leaves the format unchanged.
- R5: While transmit-request is set, `rts_n` is low and the pending interrupt drives `irq_n` low. Setting transmit-request while the holding register is empty raises a pending interrupt. With transmit-request clear, `irq_n` stays high and characters are still sent.
- R6: The holding register moves to the shift register only while `cts_n` is low. With `cts_n` low, this happens on the clock edge after the write edge, and the start bit appears on `sdo` from that edge.
- R7: The frame is: start bit 0, the word-length data bits LSB first, the parity bit if enabled, then one or two stop bits at 1. Each bit lasts 16 clocks. Data bits above the word length are not sent, and the parity covers only the bits that are sent.
- R8: The holding-empty flag sets one clock after a transfer. A character written after that flag sets begins with its start bit right after the previous stop bit.
- R9: When the shifter finishes with the holding register empty and transmit-request set, a final interrupt is raised, and status reads 0x07.
- R10: A status read clears the pending interrupt. A holding-register write clears both the holding-empty flag and the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmitter clock |
| clr_n | input | 1 | Asynchronous active-low clear |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c | input | 1 | Chip select, active high |
| reg_sel | input | 1 | Register select: 0 data registers, 1 control/status |
| rd_nwr | input | 1 | 1 read, 0 write |
| strobe | input | 1 | Access strobe, one clock wide |
| wdata | input | 8 | Write data bus |
| rdata | output | 8 | Read data bus |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| sdo | output | 1 | Serial data out, idle high |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A wrong shifter state shows on `sdo` within a single bit time, 16 clocks. A skipped parity bit, a missing second stop bit or a wrong word length shifts every later bit sample, so each frame is sampled at the centre of every bit. Wrong flag logic shows in the status byte or on `irq_n` within one or two clocks of a transfer or an access. The bench therefore samples those flags at the exact cycle after each event. A gap in back-to-back sending shows as a high level where the next start bit should be.

// File: rtl/utx_pkg.sv
package utx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic       two_stop;
        logic       even;
        logic       par_en;
        logic [1:0] wlen;
    } fmt_t;

    localparam int FMT_W  = 5;
    localparam int TR_BIT = 7;
endpackage

// File: rtl/utx_regs.sv
module utx_regs
    import utx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          sel,
    input  logic          reg_sel,
    input  logic          rd_nwr,
    input  logic          strobe,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    input  logic          shift_empty,
    output fmt_t          fmt,
    output logic          tr,
    output logic [DW-1:0] thr_data,
    output logic          thr_full,
    output logic          pend,
    output logic [DW-1:0] rdata
);
    logic wr_thr, wr_ctrl, rd_stat;
    logic thre, load_d, empty_d;
    logic ev_tr_on, ev_thre, ev_final;

    assign wr_thr  = sel && strobe && !rd_nwr && !reg_sel;
    assign wr_ctrl = sel && strobe && !rd_nwr && reg_sel;
    assign rd_stat = sel && strobe && rd_nwr && reg_sel;

    assign ev_tr_on = wr_ctrl && wdata[TR_BIT] && thre;
    assign ev_thre  = load_d && tr;
    assign ev_final = shift_empty && !empty_d && thre && tr;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            fmt      <= '0;
            tr       <= 1'b0;
            thr_data <= '0;
            thr_full <= 1'b0;
            thre     <= 1'b1;
            load_d   <= 1'b0;
            empty_d  <= 1'b1;
            pend     <= 1'b0;
        end else begin
            load_d  <= load;
            empty_d <= shift_empty;
            if (wr_ctrl) begin
                if (wdata[TR_BIT]) begin
                    tr <= 1'b1;
                end else begin
                    tr  <= 1'b0;
                    fmt <= fmt_t'(wdata[FMT_W-1:0]);
                end
            end
            if (wr_thr) begin
                thr_full <= 1'b1;
                thr_data <= wdata;
            end else if (load) begin
                thr_full <= 1'b0;
            end
            if (wr_thr)      thre <= 1'b0;
            else if (load_d) thre <= 1'b1;
            if (wr_thr || rd_stat)                  pend <= 1'b0;
            else if (ev_tr_on || ev_thre || ev_final) pend <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && rd_nwr && reg_sel) begin
            rdata[0] = thre;
            rdata[1] = shift_empty;
            rdata[2] = pend;
        end
    end

    // R4
    tr_freeze_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (wr_ctrl && wdata[TR_BIT]) |=> $stable(fmt));

    // R8
    thre_after_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_d && !wr_thr) |=> thre);

    // R10
    rd_clears_chk: assert property (@(posedge clk) disable iff (!clr_n)
        rd_stat |=> !pend);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          cts_n,
    input  logic          thr_full,
    input  logic [DW-1:0] thr_data,
    input  fmt_t          fmt,
    output logic          load,
    output logic          shift_empty,
    output logic          sdo
);
    localparam int CW       = $clog2(TICKS);
    localparam int IW       = $clog2(DW);
    localparam int MIN_BITS = DW - 3;

    tx_state_t     state, state_d;
    logic [CW-1:0] tick;
    logic [IW-1:0] bit_idx, last_idx;
    logic          stop2;
    logic [DW-1:0] shreg, sent_bits;
    fmt_t          fmt_q;
    logic          bit_end, can_load, par_bit;

    assign bit_end  = (tick == CW'(TICKS - 1));
    assign can_load = thr_full && !cts_n;
    assign last_idx = IW'(MIN_BITS - 1) + IW'(fmt_q.wlen);

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            sent_bits[i] = shreg[i] && (IW'(i) <= last_idx);
        end
        par_bit = (^sent_bits) ^ !fmt_q.even;
    end

    always_comb begin
        state_d = state;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: if (can_load) begin
                load    = 1'b1;
                state_d = ST_START;
            end
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA: if (bit_end && bit_idx == last_idx)
                state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP: if (bit_end && (!fmt_q.two_stop || stop2)) begin
                if (can_load) begin
                    load    = 1'b1;
                    state_d = ST_START;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state   <= ST_IDLE;
            tick    <= '0;
            bit_idx <= '0;
            stop2   <= 1'b0;
            shreg   <= '0;
            fmt_q   <= '0;
        end else begin
            state <= state_d;
            tick  <= (state == ST_IDLE || bit_end) ? '0 : tick + 1'b1;
            if (load) begin
                shreg <= thr_data;
                fmt_q <= fmt;
            end
            if (state == ST_START)                 bit_idx <= '0;
            else if (state == ST_DATA && bit_end)  bit_idx <= bit_idx + 1'b1;
            if (state == ST_STOP && bit_end)       stop2 <= fmt_q.two_stop && !stop2;
            else if (state != ST_STOP)             stop2 <= 1'b0;
        end
    end

    always_comb begin
        shift_empty = (state == ST_IDLE);
        unique case (state)
            ST_START:  sdo = 1'b0;
            ST_DATA:   sdo = shreg[bit_idx];
            ST_PARITY: sdo = par_bit;
            default:   sdo = 1'b1;
        endcase
    end

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (state == ST_IDLE && cts_n) |=> (state == ST_IDLE));

    // R7
    bit_range_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (state == ST_DATA) |-> (bit_idx <= last_idx));
endmodule

// File: rtl/bus_uart_tx.sv
module bus_uart_tx
    import utx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          cs_a,
    input  logic          cs_b,
    input  logic          cs_c,
    input  logic          reg_sel,
    input  logic          rd_nwr,
    input  logic          strobe,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          cts_n,
    output logic          rts_n,
    output logic          sdo,
    output logic          irq_n
);
    fmt_t          fmt;
    logic          tr, thr_full, pend, load, shift_empty;
    logic [DW-1:0] thr_data;

    utx_regs #(.DW(DW)) u_regs (
        .clk(clk), .clr_n(clr_n), .sel(cs_a && cs_b && cs_c),
        .reg_sel(reg_sel), .rd_nwr(rd_nwr), .strobe(strobe), .wdata(wdata),
        .load(load), .shift_empty(shift_empty), .fmt(fmt), .tr(tr),
        .thr_data(thr_data), .thr_full(thr_full), .pend(pend), .rdata(rdata)
    );

    utx_shifter #(.DW(DW), .TICKS(TICKS)) u_shift (
        .clk(clk), .clr_n(clr_n), .cts_n(cts_n), .thr_full(thr_full),
        .thr_data(thr_data), .fmt(fmt), .load(load),
        .shift_empty(shift_empty), .sdo(sdo)
    );

    assign rts_n = !tr;
    assign irq_n = !(pend && tr);

    // R9
    final_irq_chk: assert property (@(posedge clk) disable iff (!clr_n)
        ($rose(shift_empty) && tr && !thr_full && !load) |=> ##1 !irq_n);
endmodule

// File: tb/test_bus_uart_tx.sv
`timescale 1ns/1ps
module test_bus_uart_tx;
    logic       clk = 1'b0, clr_n = 1'b0;
    logic       cs_a = 1'b1, cs_b = 1'b1, cs_c = 1'b1;
    logic       reg_sel = 1'b0, rd_nwr = 1'b0, strobe = 1'b0, cts_n = 1'b0;
    logic [7:0] wdata = 8'h00, rdata;
    logic       rts_n, sdo, irq_n;
    int         cyc = 0, n_vec = 0, n_bad = 0;

    bus_uart_tx i_bus_uart_tx (
        .clk(clk), .clr_n(clr_n), .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c),
        .reg_sel(reg_sel), .rd_nwr(rd_nwr), .strobe(strobe), .wdata(wdata),
        .rdata(rdata), .cts_n(cts_n), .rts_n(rts_n), .sdo(sdo), .irq_n(irq_n)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // {ctrl, data, frame length in bits}
    localparam logic [23:0] VEC [6] = '{
        {8'h03, 8'hA5, 8'd10},
        {8'h07, 8'h3C, 8'd11},
        {8'h0F, 8'h81, 8'd11},
        {8'h10, 8'hFF, 8'd8},
        {8'h05, 8'hC2, 8'd9},
        {8'h1E, 8'h55, 8'd11}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic rs, input logic [7:0] d, input logic [2:0] cs = 3'b111);
        @(negedge clk);
        {cs_a, cs_b, cs_c} = cs;
        reg_sel = rs; rd_nwr = 1'b0; wdata = d; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; {cs_a, cs_b, cs_c} = 3'b111;
    endtask

    task automatic rd(input logic rs, output logic [7:0] v);
        @(negedge clk);
        reg_sel = rs; rd_nwr = 1'b1; strobe = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        strobe = 1'b0; rd_nwr = 1'b0;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    function automatic logic fbit(input logic [7:0] c, input logic [7:0] d, input int k);
        int  n = 5 + int'(c[1:0]);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p ^= d[i];
        if (k == 0) return 1'b0;
        if (k <= n) return d[k-1];
        if (c[2] && k == n + 1) return p ^ !c[3];
        return 1'b1;
    endfunction

    function automatic int flen(input logic [7:0] c);
        return 7 + int'(c[1:0]) + int'(c[2]) + int'(c[4]);
    endfunction

    // sample bits k0..k1 of a frame whose start edge follows write edge e
    task automatic chk_frame(input logic [7:0] c, input logic [7:0] d, input int e,
                             input int k0, input int k1, input string tag);
        for (int k = k0; k <= k1; k++) begin
            wait_cyc(e + 8 + 16 * k);
            chk({7'd0, sdo}, {7'd0, fbit(c, d, k)}, $sformatf("%s bit%0d", tag, k));
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int e;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk({7'd0, sdo}, 8'd1, "R2 sdo idle after clear");
        chk({7'd0, rts_n}, 8'd1, "R2 rts_n after clear");
        chk({7'd0, irq_n}, 8'd1, "R5 irq_n after clear");
        clr_n = 1'b1;
        rd(1'b1, v); chk(v, 8'h03, "R1 status after reset");
        rd(1'b0, v); chk(v, 8'h00, "R1 receive holding read");

        // table walk: R7 frames with transmit-request clear (R5)
        foreach (VEC[i]) begin
            logic [7:0] c, d;
            c = VEC[i][23:16]; d = VEC[i][15:8];
            chk(8'(flen(c)), VEC[i][7:0], "R7 frame length table");
            wr(1'b1, c);
            wr(1'b0, d); e = cyc;
            chk_frame(c, d, e, 0, flen(c), $sformatf("R7 vec%0d", i));
            wait_cyc(e + 8 + 16 * flen(c) + 8);
            rd(1'b1, v); chk(v, 8'h03, "R7 status after frame");
            chk({7'd0, irq_n}, 8'd1, "R5 no irq with request clear");
        end

        // R3 chip select gating
        wr(1'b0, 8'h00, 3'b101); e = cyc;
        wait_cyc(e + 40);
        chk({7'd0, sdo}, 8'd1, "R3 no send without cs_b");
        rd(1'b1, v); chk(v, 8'h03, "R3 status untouched");
        wr(1'b1, 8'h80, 3'b110);
        chk({7'd0, rts_n}, 8'd1, "R3 control write ignored without cs_c");

        // R6 clear-to-send hold
        wr(1'b1, 8'h03);
        cts_n = 1'b1;
        wr(1'b0, 8'h0F); e = cyc;
        wait_cyc(e + 40);
        chk({7'd0, sdo}, 8'd1, "R6 held while cts_n high");
        rd(1'b1, v); chk(v, 8'h02, "R6 holding full, shifter empty");
        @(negedge clk); cts_n = 1'b0; e = cyc;
        chk_frame(8'h03, 8'h0F, e, 0, 10, "R6 after cts_n low");

        // R4 freeze: format 8N1, then request with parity bits set
        wr(1'b1, 8'h87);
        chk({7'd0, rts_n}, 8'd0, "R5 rts_n low with request");
        chk({7'd0, irq_n}, 8'd0, "R5 irq on request with empty holding");
        wr(1'b0, 8'h07); e = cyc;
        chk({7'd0, irq_n}, 8'd1, "R10 holding write clears irq");
        chk_frame(8'h03, 8'h07, e, 0, 10, "R4 format frozen");

        // R8 back-to-back, R9 final interrupt
        wait_cyc(e + 200);
        rd(1'b1, v);
        wr(1'b0, 8'h5A); e = cyc;
        wait_cyc(e + 1);
        chk({7'd0, irq_n}, 8'd1, "R8 flag not yet set one edge after write");
        wait_cyc(e + 2);
        chk({7'd0, irq_n}, 8'd0, "R8 holding-empty irq after transfer");
        rd(1'b1, v); chk(v, 8'h05, "R8 status holding empty, shifter busy");
        chk({7'd0, irq_n}, 8'd1, "R10 status read clears irq");
        wr(1'b0, 8'hC3);
        chk_frame(8'h03, 8'h5A, e, 0, 9, "R8 first char");
        for (int k = 0; k <= 9; k++) begin
            wait_cyc(e + 168 + 16 * k);
            chk({7'd0, sdo}, {7'd0, fbit(8'h03, 8'hC3, k)}, $sformatf("R8 second char bit%0d", k));
            if (k == 2) rd(1'b1, v);
        end
        wait_cyc(e + 324);
        chk({7'd0, irq_n}, 8'd0, "R9 final irq");
        rd(1'b1, v); chk(v, 8'h07, "R9 status both empty");
        wr(1'b1, 8'h03);
        chk({7'd0, rts_n}, 8'd1, "R5 rts_n high after request cleared");

        // R2 clear mid-frame
        wr(1'b0, 8'h00); e = cyc;
        wait_cyc(e + 24);
        chk({7'd0, sdo}, 8'd0, "R2 data bit before clear");
        clr_n = 1'b0;
        #1 chk({7'd0, sdo}, 8'd1, "R2 sdo high on clear");
        rd(1'b1, v); chk(v, 8'h03, "R2 status on clear");
        @(negedge clk); clr_n = 1'b1;
        wr(1'b0, 8'h00); e = cyc;
        chk_frame(8'h00, 8'h00, e, 0, 7, "R2 format reset to 5N1");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule